// File: doc/BRIEF.md
# Half-Staggered Dual-Rate Integer ALU

This block is a 32-bit integer unit clocked by a fast clock that runs at twice the core clock. Every operation is sliced across two consecutive fast cycles. The low 16 bits of the result are formed in the issue cycle. The high 16 bits are formed in the following fast cycle, using a carry that was registered between the two slices. A new operation may be issued on every fast-clock edge, which gives two issues per core cycle.

The unit holds a small register file. Each operand is chosen by comparing its source index against the destination tags of the operations still in flight. A low half is forwarded from the first slice of the operation issued one fast cycle earlier. A high half is forwarded from that operation's second slice at the moment the dependent operation needs it. The result is that a read-after-write dependent operation can issue only one fast cycle behind its producer. Each finished 32-bit result appears on a writeback port together with its destination index, and is written into the register file on the same edge.

Top module: `halfslice_alu`

## Requirements
- R1: An active-high synchronous reset clears every in-flight valid bit and sets all registers to zero. While reset is held and after it is released, `wbValid` stays low until an operation is issued.
- R2: An operation sampled with `issueValid` high on a rising edge appears on the writeback port two fast cycles later, with `wbIdx` equal to its destination index. Back-to-back issues produce back-to-back writebacks in issue order.
- R3: Opcode 0 (add) gives (A + B) mod 2^32, including the carry from bit 15 into bit 16.
- R4: Opcode 1 (subtract) gives (A − B) mod 2^32, including the borrow across the half boundary.
- R5: Opcodes 2, 3 and 4 give bitwise AND, OR and XOR. No carry from the low half affects bits 31:16.
- R6: Opcodes 5, 6 and 7 behave exactly as add.
- R7: When `issueUseImm` is high, operand B is `issueImm`, and the B source index has no effect on the result.
- R8: An operation whose source is the destination of an operation issued one or two fast cycles earlier receives that operation's full result. The results match strict one-at-a-time program order.
- R9: When several in-flight operations target the register that a source reads, the most recently issued one supplies the value.
- R10: A completed result is written to its destination register, so any later operation reads it from the register file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock (twice the core rate) |
| rst | input | 1 | Synchronous active-high reset |
| issueValid | input | 1 | An operation is presented this cycle |
| issueOp | input | 3 | Opcode: 0 add, 1 sub, 2 and, 3 or, 4 xor, 5..7 add |
| issueSrcA | input | IDX_W (3) | Register index for operand A |
| issueSrcB | input | IDX_W (3) | Register index for operand B |
| issueUseImm | input | 1 | Take operand B from `issueImm` |
| issueImm | input | XLEN (32) | Immediate value for operand B |
| issueDest | input | IDX_W (3) | Destination register index (tag) |
| wbValid | output | 1 | A result is on the writeback port |
| wbIdx | output | IDX_W (3) | Destination index of the result |
| wbData | output | XLEN (32) | Full 32-bit result |

## Verification
Directed chains build values near the 16-bit boundary, such as 0x0000FFFF plus one, and a subtraction from zero. These expose a missing or misrouted carry between the slices and show whether logic operations leak a carry. Producer–consumer pairs at distances of one, two and three issues separate the first-slice bypass from the second-slice bypass and from the register-file path. Two writes to the same register followed by a read show whether the newer producer wins. A long random stream then mixes dependent and independent operations, immediates and idle gaps, and is checked against an in-order reference model.

// File: rtl/halfslice_pkg.sv
package halfslice_pkg;

  localparam logic [2:0] OPC_ADD = 3'd0;
  localparam logic [2:0] OPC_SUB = 3'd1;
  localparam logic [2:0] OPC_AND = 3'd2;
  localparam logic [2:0] OPC_OR  = 3'd3;
  localparam logic [2:0] OPC_XOR = 3'd4;

  typedef enum logic [1:0] {
    SRC_RF  = 2'd0,
    SRC_S1  = 2'd1,
    SRC_S2  = 2'd2,
    SRC_IMM = 2'd3
  } srcSel_e;

  typedef enum logic [1:0] {
    FN_ARITH = 2'd0,
    FN_AND   = 2'd1,
    FN_OR    = 2'd2,
    FN_XOR   = 2'd3
  } fnSel_e;

  typedef struct packed {
    srcSel_e selA;
    srcSel_e selB;
    fnSel_e  issueFn;
    logic    issueSub;
    fnSel_e  s1Fn;
    logic    s1Sub;
    logic    s1HiFwdA;
    logic    s1HiFwdB;
    logic    wrEn;
  } strobes_t;

endpackage

// File: rtl/halfslice_ctrl.sv
module halfslice_ctrl
  import halfslice_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issueValid,
  input  logic [2:0]       issueOp,
  input  logic [IDX_W-1:0] issueSrcA,
  input  logic [IDX_W-1:0] issueSrcB,
  input  logic             issueUseImm,
  input  logic [IDX_W-1:0] issueDest,
  output strobes_t         st,
  output logic             s2Valid,
  output logic [IDX_W-1:0] s2Dest
);

  logic             s1Valid;
  logic [IDX_W-1:0] s1Dest;
  fnSel_e           s1Fn;
  logic             s1Sub;
  logic             s1HiFwdA;
  logic             s1HiFwdB;

  logic    hitS1A, hitS2A, hitS1B, hitS2B;
  srcSel_e selA, selB;
  fnSel_e  issueFn;
  logic    issueSub;

  always_comb begin
    hitS1A = s1Valid && (s1Dest == issueSrcA);
    hitS2A = s2Valid && (s2Dest == issueSrcA);
    hitS1B = s1Valid && (s1Dest == issueSrcB);
    hitS2B = s2Valid && (s2Dest == issueSrcB);

    if (hitS1A)      selA = SRC_S1;
    else if (hitS2A) selA = SRC_S2;
    else             selA = SRC_RF;

    if (issueUseImm) selB = SRC_IMM;
    else if (hitS1B) selB = SRC_S1;
    else if (hitS2B) selB = SRC_S2;
    else             selB = SRC_RF;

    issueSub = 1'b0;
    case (issueOp)
      OPC_SUB: begin issueFn = FN_ARITH; issueSub = 1'b1; end
      OPC_AND: issueFn = FN_AND;
      OPC_OR:  issueFn = FN_OR;
      OPC_XOR: issueFn = FN_XOR;
      default: issueFn = FN_ARITH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1Valid <= 1'b0;
      s2Valid <= 1'b0;
    end else begin
      s1Valid <= issueValid;
      s2Valid <= s1Valid;
    end
    s1Dest   <= issueDest;
    s1Fn     <= issueFn;
    s1Sub    <= issueSub;
    s1HiFwdA <= (selA == SRC_S1);
    s1HiFwdB <= (selB == SRC_S1);
    s2Dest   <= s1Dest;
  end

  always_comb begin
    st.selA     = selA;
    st.selB     = selB;
    st.issueFn  = issueFn;
    st.issueSub = issueSub;
    st.s1Fn     = s1Fn;
    st.s1Sub    = s1Sub;
    st.s1HiFwdA = s1HiFwdA;
    st.s1HiFwdB = s1HiFwdB;
    st.wrEn     = s2Valid;
  end

  // R9: the producer issued one cycle ago outranks the older one
  a_r9_newest_wins: assert property (@(posedge clk) disable iff (rst)
    (issueValid && s1Valid && s2Valid && (s1Dest == s2Dest) && (issueSrcA == s1Dest))
      |=> s1HiFwdA);

  // R8: a one-cycle-old producer always hands its high half forward
  a_r8_hi_follow: assert property (@(posedge clk) disable iff (rst)
    (s1HiFwdA && s1Valid) |-> s2Valid);

endmodule

// File: rtl/halfslice_dp.sv
module halfslice_dp
  import halfslice_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREGS = 8,
  parameter int IDX_W = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  strobes_t         st,
  input  logic [IDX_W-1:0] srcA,
  input  logic [IDX_W-1:0] srcB,
  input  logic [XLEN-1:0]  imm,
  input  logic [IDX_W-1:0] wrIdx,
  output logic [XLEN-1:0]  wbData
);

  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] regFile [NREGS];
  logic [HALF-1:0] s1Lo;
  logic            s1Carry;
  logic [HALF-1:0] s1HiA, s1HiB;
  logic [XLEN-1:0] s2Res;

  logic [XLEN-1:0] opA, opB;
  logic [HALF-1:0] loB, loRes;
  logic [HALF:0]   loSum;
  logic [HALF-1:0] hiA, hiB, hiBx, hiRes;

  function automatic logic [XLEN-1:0] pickSrc(srcSel_e sel, logic [XLEN-1:0] rfVal,
                                              logic [HALF-1:0] lo1, logic [XLEN-1:0] full2,
                                              logic [XLEN-1:0] immVal);
    case (sel)
      SRC_S1:  return {{HALF{1'b0}}, lo1};
      SRC_S2:  return full2;
      SRC_IMM: return immVal;
      default: return rfVal;
    endcase
  endfunction

  // first slice: low half at issue
  always_comb begin
    opA   = pickSrc(st.selA, regFile[srcA], s1Lo, s2Res, imm);
    opB   = pickSrc(st.selB, regFile[srcB], s1Lo, s2Res, imm);
    loB   = st.issueSub ? ~opB[HALF-1:0] : opB[HALF-1:0];
    loSum = {1'b0, opA[HALF-1:0]} + {1'b0, loB} + {{HALF{1'b0}}, st.issueSub};
    case (st.issueFn)
      FN_AND:  loRes = opA[HALF-1:0] & opB[HALF-1:0];
      FN_OR:   loRes = opA[HALF-1:0] | opB[HALF-1:0];
      FN_XOR:  loRes = opA[HALF-1:0] ^ opB[HALF-1:0];
      default: loRes = loSum[HALF-1:0];
    endcase
  end

  // second slice: high half one fast cycle later
  always_comb begin
    hiA  = st.s1HiFwdA ? s2Res[XLEN-1:HALF] : s1HiA;
    hiB  = st.s1HiFwdB ? s2Res[XLEN-1:HALF] : s1HiB;
    hiBx = st.s1Sub ? ~hiB : hiB;
    case (st.s1Fn)
      FN_AND:  hiRes = hiA & hiB;
      FN_OR:   hiRes = hiA | hiB;
      FN_XOR:  hiRes = hiA ^ hiB;
      default: hiRes = hiA + hiBx + {{(HALF-1){1'b0}}, s1Carry};
    endcase
  end

  always_ff @(posedge clk) begin
    s1Lo    <= loRes;
    s1Carry <= loSum[HALF];
    s1HiA   <= opA[XLEN-1:HALF];
    s1HiB   <= opB[XLEN-1:HALF];
    s2Res   <= {hiRes, s1Lo};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) regFile[i] <= '0;
    end else if (st.wrEn) begin
      regFile[wrIdx] <= s2Res;
    end
  end

  assign wbData = s2Res;

  // R10: a writeback lands in the addressed register
  a_r10_rf_written: assert property (@(posedge clk) disable iff (rst)
    ($past(st.wrEn) && !$past(rst)) |-> (regFile[$past(wrIdx)] == $past(wbData)));

endmodule

// File: rtl/halfslice_alu.sv
module halfslice_alu
  import halfslice_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREGS = 8,
  parameter int IDX_W = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issueValid,
  input  logic [2:0]       issueOp,
  input  logic [IDX_W-1:0] issueSrcA,
  input  logic [IDX_W-1:0] issueSrcB,
  input  logic             issueUseImm,
  input  logic [XLEN-1:0]  issueImm,
  input  logic [IDX_W-1:0] issueDest,
  output logic             wbValid,
  output logic [IDX_W-1:0] wbIdx,
  output logic [XLEN-1:0]  wbData
);

  strobes_t st;

  halfslice_ctrl #(.IDX_W(IDX_W)) ctrlInst (
    .clk(clk), .rst(rst),
    .issueValid(issueValid), .issueOp(issueOp),
    .issueSrcA(issueSrcA), .issueSrcB(issueSrcB),
    .issueUseImm(issueUseImm), .issueDest(issueDest),
    .st(st), .s2Valid(wbValid), .s2Dest(wbIdx)
  );

  halfslice_dp #(.XLEN(XLEN), .NREGS(NREGS), .IDX_W(IDX_W)) dpInst (
    .clk(clk), .rst(rst), .st(st),
    .srcA(issueSrcA), .srcB(issueSrcB), .imm(issueImm),
    .wrIdx(wbIdx), .wbData(wbData)
  );

  // R2: every issue reaches writeback two fast cycles later
  a_r2_latency: assert property (@(posedge clk) disable iff (rst)
    issueValid |-> ##2 wbValid);

  // R2: no writeback without a matching issue
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    wbValid |-> $past(issueValid, 2));

  // R2: the writeback carries the destination tag of its issue
  a_r2_dest_tag: assert property (@(posedge clk) disable iff (rst)
    wbValid |-> (wbIdx == $past(issueDest, 2)));

  // R1: reset empties the pipeline
  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> !wbValid);

endmodule

// File: tb/halfslice_alu_test.sv
`timescale 1ns/1ps
module halfslice_alu_test;

  localparam int XLEN  = 32;
  localparam int NREGS = 8;
  localparam int IDX_W = 3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             issueValid = 1'b0;
  logic [2:0]       issueOp = '0;
  logic [IDX_W-1:0] issueSrcA = '0;
  logic [IDX_W-1:0] issueSrcB = '0;
  logic             issueUseImm = 1'b0;
  logic [XLEN-1:0]  issueImm = '0;
  logic [IDX_W-1:0] issueDest = '0;
  logic             wbValid;
  logic [IDX_W-1:0] wbIdx;
  logic [XLEN-1:0]  wbData;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [XLEN-1:0] refRegs [NREGS];
  int              expIdx  [$];
  logic [XLEN-1:0] expData [$];
  string           expTag  [$];

  always #2 clk = ~clk;

  halfslice_alu #(.XLEN(XLEN), .NREGS(NREGS), .IDX_W(IDX_W)) uut (
    .clk(clk), .rst(rst), .issueValid(issueValid), .issueOp(issueOp),
    .issueSrcA(issueSrcA), .issueSrcB(issueSrcB), .issueUseImm(issueUseImm),
    .issueImm(issueImm), .issueDest(issueDest),
    .wbValid(wbValid), .wbIdx(wbIdx), .wbData(wbData)
  );

  function automatic logic [XLEN-1:0] refExec(logic [2:0] op, logic [XLEN-1:0] a, logic [XLEN-1:0] b);
    case (op)
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return a ^ b;
      default: return a + b;
    endcase
  endfunction

  task automatic check(bit ok, string tag, logic [XLEN-1:0] got, logic [XLEN-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic issue(logic [2:0] op, int a, int b, bit useImm, logic [XLEN-1:0] imm,
                       int dest, string tag);
    logic [XLEN-1:0] bv, res;
    @(negedge clk);
    issueValid  = 1'b1;
    issueOp     = op;
    issueSrcA   = IDX_W'(a);
    issueSrcB   = IDX_W'(b);
    issueUseImm = useImm;
    issueImm    = imm;
    issueDest   = IDX_W'(dest);
    bv  = useImm ? imm : refRegs[b];
    res = refExec(op, refRegs[a], bv);
    refRegs[dest] = res;
    expIdx.push_back(dest);
    expData.push_back(res);
    expTag.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      issueValid = 1'b0;
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && wbValid) begin
      if (expIdx.size() == 0) begin
        check(1'b0, "R2 unexpected writeback", wbData, '0);
      end else begin
        int ei;
        logic [XLEN-1:0] ed;
        string et;
        ei = expIdx.pop_front();
        ed = expData.pop_front();
        et = expTag.pop_front();
        check((wbData == ed) && (int'(wbIdx) == ei), et, wbData, ed);
        if (int'(wbIdx) != ei)
          $display("  index got %0d expected %0d", wbIdx, ei);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int lastDest;
    for (int i = 0; i < NREGS; i++) refRegs[i] = '0;
    repeat (3) @(negedge clk);
    check(wbValid == 1'b0, "R1 writeback idle in reset", {31'd0, wbValid}, '0);
    @(negedge clk);
    rst = 1'b0;
    idle(2);
    check(wbValid == 1'b0, "R1 writeback idle after reset", {31'd0, wbValid}, '0);

    // R1: every register reads zero after reset
    for (int r = 0; r < NREGS; r++) issue(3'd3, r, r, 1'b0, '0, r, "R1 register cleared");
    idle(3);

    // R7: immediate load; B index points at a nonzero register and must not matter
    issue(3'd0, 0, 0, 1'b1, 32'h1234_5678, 5, "R7 immediate load");
    idle(3);
    issue(3'd0, 0, 5, 1'b1, 32'h0000_FFFF, 1, "R7 B index ignored");
    // R3 R8: dependent one cycle behind, carry crosses bit 15
    issue(3'd0, 1, 0, 1'b1, 32'h0000_0001, 2, "R3 R8 carry into high half");
    // R4 R8: forwards from both bypass stages at once
    issue(3'd1, 2, 1, 1'b0, '0, 3, "R4 R8 sub from two producers");
    issue(3'd1, 0, 3, 1'b0, '0, 4, "R4 borrow through all bits");
    // R5: logic ops, carry would matter if leaked
    issue(3'd2, 4, 5, 1'b0, '0, 6, "R5 and");
    issue(3'd3, 1, 5, 1'b0, '0, 6, "R5 or");
    issue(3'd4, 6, 0, 1'b1, 32'h0001_FFFF, 7, "R5 xor no carry leak");
    issue(3'd2, 1, 0, 1'b1, 32'h0000_FFFF, 7, "R5 and no carry leak");
    // R6: spare opcodes add
    issue(3'd5, 1, 0, 1'b1, 32'h0000_0001, 7, "R6 opcode 5 adds");
    issue(3'd7, 7, 1, 1'b0, '0, 6, "R6 opcode 7 adds");
    idle(2);
    // R9: two producers of r3 in flight, the newer wins
    issue(3'd0, 0, 0, 1'b1, 32'd5, 3, "R9 older producer");
    issue(3'd0, 0, 0, 1'b1, 32'd9, 3, "R9 newer producer");
    issue(3'd0, 3, 3, 1'b0, '0, 4, "R9 reads newest value");
    // R8: distance two, second-stage bypass
    issue(3'd0, 0, 0, 1'b1, 32'hABCD_0001, 2, "R8 producer");
    idle(1);
    issue(3'd1, 2, 0, 1'b1, 32'h0000_0002, 4, "R8 distance two");
    // R10: distance three, register file path
    issue(3'd0, 0, 0, 1'b1, 32'h7FFF_FFFF, 1, "R10 producer");
    idle(2);
    issue(3'd0, 1, 1, 1'b0, '0, 2, "R10 read from register file");
    idle(4);

    // random stream, dependent and independent
    lastDest = 0;
    for (int n = 0; n < 600; n++) begin
      int a, b, d, gap;
      bit ui;
      a  = ($urandom % 2 == 0) ? lastDest : int'($urandom % NREGS);
      b  = ($urandom % 3 == 0) ? lastDest : int'($urandom % NREGS);
      d  = int'($urandom % NREGS);
      ui = ($urandom % 4 == 0);
      issue(3'($urandom % 8), a, b, ui, $urandom, d, "R2 R8 random stream");
      lastDest = d;
      gap = int'($urandom % 4);
      if (gap == 0) idle(1);
    end
    idle(5);
    check(expIdx.size() == 0, "R2 all results written back", 32'(expIdx.size()), '0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule